// File: doc/BRIEF.md
# Address-Bus Vectored Interrupt Controller

This block sits beside a CPU that learns its interrupt vector from the address bus instead of from the data bus. Up to eight interrupt sources feed it. A request that is high for a single clock is captured and held. While any enabled request is held, the block holds the CPU's active-low interrupt line low. The block watches the CPU's 2-bit bus status and its clock phase. On the first instruction fetch with a request pending, the CPU drives A15..A2 high. The block then pulls chosen lines low through an open-drain enable mask, so that the bus reads the vector of the winning source. When the CPU signals the acknowledge code, the block releases the lines and retires that source. It then presents the next pending source, if there is one.

Each source has a programmable 14-bit vector that stands for address bits 15..2; bits 1..0 of the vector are always zero. An all-ones entry gives the default interrupt vector 0xFFFC. A separate CPU reset request uses the same path. It holds the interrupt line low and pulls only A2, which gives the vector 0xFFF8. The CPU starts running when the request is dropped.

Top module: `vec_irq_ctl`

## Requirements
- R1: Bus status code 2'b10 sampled while cpu_clk is low marks an instruction fetch. Code 2'b11 sampled while cpu_clk is low marks an acknowledge. Codes 2'b01 and 2'b00, and any code seen while cpu_clk is high, start nothing.
- R2: A request bit that is high on one rising clk edge stays pending until its own acknowledge. It needs no further request input.
- R3: irq_n goes low one clock after an enabled source becomes pending, and it is high when no enabled source is pending. A source whose irq_en bit is 0 does not drive irq_n low, but it stays pending and counts again once it is enabled.
- R4: When several enabled sources are pending, the source with the lowest index is presented first.
- R5: One clock after a fetch edge that finds an enabled source pending, addr_pull equals the bitwise inverse of that source's 14-bit vector. Bit k of addr_pull pulls address line A(k+2), and the vector of source i sits in vec_table[i*14 +: 14]. The chosen source is frozen at that edge, so a request that arrives later in the fetch cannot change addr_pull.
- R6: Outside a CPU reset request, addr_pull is nonzero only in the clock after an edge that sampled status 2'b10. One clock after status leaves 2'b10, addr_pull is zero, even when no acknowledge has come yet.
- R7: One clock after an acknowledge edge, addr_pull is zero, the served source is no longer pending, and irq_n shows whether any other enabled source is still pending.
- R8: One clock after any edge at which cpu_rst_req is high, irq_n is 0 and addr_pull is 14'h0001, which pulls A2 alone. This holds whatever the bus status is, and it abandons any vector in progress. One clock after cpu_rst_req drops, addr_pull is zero and irq_n again follows the pending enabled sources.
- R9: A source whose vector is all ones, the default vector 0xFFFC, produces addr_pull = 0 during its fetch.
- R10: If a source's request is still high at its acknowledge edge, the source is pending again right after the acknowledge.
- R11: After rst_n is released, irq_n is 1, addr_pull is 0 and no source is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | 8 | Request from each source, active high |
| irq_en | input | 8 | Enable for each source |
| vec_table | input | 112 | 14-bit vector (address bits 15..2) for each source; source i at [i*14 +: 14] |
| bus_status | input | 2 | CPU bus status: 11 acknowledge, 10 fetch, 01 data, 00 internal |
| cpu_clk | input | 1 | CPU clock phase; the status is only acted on while it is low |
| cpu_rst_req | input | 1 | Holds the CPU in reset through the interrupt path |
| irq_n | output | 1 | Active-low interrupt line to the CPU |
| addr_pull | output | 14 | Open-drain enables; bit k pulls A(k+2) low |

## Verification
Every output comes from a register, so each result is due exactly one controller clock after the edge that samples its cause. Pending state and irq_n follow one clock after a request. addr_pull follows one clock after the fetch edge. Release and the next irq_n level follow one clock after the acknowledge edge, and the reset-vector pattern follows one clock after cpu_rst_req is seen. The bench changes inputs on the falling clk edge and reads the outputs 1 ns after the next rising edge. Each table row and each directed step therefore checks the result of the single edge just taken.

// File: rtl/vec_irq_pkg.sv
package vec_irq_pkg;

    // CPU bus status encodings
    typedef enum logic [1:0] {
        BS_INTERNAL = 2'b00,
        BS_DATA     = 2'b01,
        BS_FETCH    = 2'b10,
        BS_ACK      = 2'b11
    } bus_code_t;

    // controller sequencing
    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_DRIVE = 2'b01,
        ST_WAIT  = 2'b10
    } ctl_state_t;

endpackage

// File: rtl/vec_irq_latch.sv
module vec_irq_latch #(
    parameter int NUM_SRC = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] set_i,
    input  logic [NUM_SRC-1:0] clr_i,
    output logic [NUM_SRC-1:0] pend_o,
    output logic [NUM_SRC-1:0] pend_nx_o
);

    logic [NUM_SRC-1:0] pend_d;
    logic [NUM_SRC-1:0] pend_q;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_bit
        // a new request wins over the clear of the same source
        always_comb begin
            pend_d[g] = set_i[g] | (pend_q[g] & ~clr_i[g]);
        end

        // R2: a single-clock request is captured
        a_r2_capture: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[g] |=> pend_o[g]);

        // R2: pending only drops through a clear
        a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (pend_o[g] && !clr_i[g]) |=> pend_o[g]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            pend_q <= pend_d;
        end
    end

    assign pend_o    = pend_q;
    assign pend_nx_o = pend_d;

endmodule

// File: rtl/vec_irq_pick.sv
module vec_irq_pick #(
    parameter int NUM_SRC = 8,
    localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic [NUM_SRC-1:0] req_i,
    output logic [NUM_SRC-1:0] grant_o,
    output logic [IDX_W-1:0]   idx_o,
    output logic               valid_o
);

    // lower[i] is set when any source below i requests
    logic [NUM_SRC:0] lower;

    assign lower[0] = 1'b0;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_chain
        assign lower[g+1]  = lower[g] | req_i[g];
        assign grant_o[g]  = req_i[g] & ~lower[g];
    end

    assign valid_o = lower[NUM_SRC];

    always_comb begin
        idx_o = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (grant_o[i]) begin
                idx_o = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/vec_irq_vmux.sv
module vec_irq_vmux #(
    parameter int NUM_SRC = 8,
    parameter int VEC_W   = 14,
    localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic [NUM_SRC*VEC_W-1:0] vec_flat_i,
    input  logic [IDX_W-1:0]         idx_i,
    output logic [VEC_W-1:0]         pull_o
);

    logic [VEC_W-1:0] entry [NUM_SRC];

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_unpack
        assign entry[g] = vec_flat_i[g*VEC_W +: VEC_W];
    end

    // a line reads 0 where it is pulled, so pull where the vector bit is 0
    assign pull_o = ~entry[idx_i];

endmodule

// File: rtl/vec_irq_ctl.sv
module vec_irq_ctl
    import vec_irq_pkg::*;
#(
    parameter int NUM_SRC = 8,
    parameter int VEC_W   = 14
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_SRC-1:0]       irq_req,
    input  logic [NUM_SRC-1:0]       irq_en,
    input  logic [NUM_SRC*VEC_W-1:0] vec_table,
    input  logic [1:0]               bus_status,
    input  logic                     cpu_clk,
    input  logic                     cpu_rst_req,
    output logic                     irq_n,
    output logic [VEC_W-1:0]         addr_pull
);

    localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
    // the reset vector differs from the default only in A2, the lowest line
    localparam logic [VEC_W-1:0] RST_PULL = VEC_W'(1);

    typedef struct packed {
        ctl_state_t       state;
        logic [IDX_W-1:0] sel;
        logic [VEC_W-1:0] pull;
        logic             irq_n;
    } ctl_t;

    ctl_t ctl_d;
    ctl_t ctl_q;

    logic               fetch_now;
    logic               ack_now;
    logic               fetch_code;
    logic [NUM_SRC-1:0] pend;
    logic [NUM_SRC-1:0] pend_nx;
    logic [NUM_SRC-1:0] clr;
    logic [NUM_SRC-1:0] live;
    logic [NUM_SRC-1:0] grant;
    logic [IDX_W-1:0]   win_idx;
    logic               win_valid;
    logic [VEC_W-1:0]   win_pull;

    // R1: status only counts in the low half of the CPU clock
    assign fetch_code = (bus_status == BS_FETCH);
    assign fetch_now  = fetch_code && !cpu_clk;
    assign ack_now    = (bus_status == BS_ACK) && !cpu_clk;

    vec_irq_latch #(
        .NUM_SRC (NUM_SRC)
    ) u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_i     (irq_req),
        .clr_i     (clr),
        .pend_o    (pend),
        .pend_nx_o (pend_nx)
    );

    assign live = pend & irq_en;

    vec_irq_pick #(
        .NUM_SRC (NUM_SRC)
    ) u_pick (
        .req_i   (live),
        .grant_o (grant),
        .idx_o   (win_idx),
        .valid_o (win_valid)
    );

    vec_irq_vmux #(
        .NUM_SRC (NUM_SRC),
        .VEC_W   (VEC_W)
    ) u_vmux (
        .vec_flat_i (vec_table),
        .idx_i      (win_idx),
        .pull_o     (win_pull)
    );

    always_comb begin
        ctl_d = ctl_q;
        clr   = '0;

        if (cpu_rst_req) begin
            // R8: reset takes the same path and abandons any vector
            ctl_d.state = ST_IDLE;
            ctl_d.pull  = RST_PULL;
        end else begin
            unique case (ctl_q.state)
                ST_IDLE: begin
                    ctl_d.pull = '0;
                    if (fetch_now && win_valid) begin
                        // R5: source frozen here for the whole cycle
                        ctl_d.state = ST_DRIVE;
                        ctl_d.sel   = win_idx;
                        ctl_d.pull  = win_pull;
                    end
                end
                ST_DRIVE: begin
                    if (ack_now) begin
                        clr[ctl_q.sel] = 1'b1;
                        ctl_d.pull     = '0;
                        ctl_d.state    = ST_IDLE;
                    end else if (!fetch_code) begin
                        // R6: fetch over, lines released, ack still owed
                        ctl_d.pull  = '0;
                        ctl_d.state = ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    ctl_d.pull = '0;
                    if (ack_now) begin
                        clr[ctl_q.sel] = 1'b1;
                        ctl_d.state    = ST_IDLE;
                    end
                end
                default: begin
                    ctl_d.pull  = '0;
                    ctl_d.state = ST_IDLE;
                end
            endcase
        end

        // R3/R7: line level follows the pending set after this edge
        ctl_d.irq_n = cpu_rst_req ? 1'b0 : ~(|(pend_nx & irq_en));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.state <= ST_IDLE;
            ctl_q.sel   <= '0;
            ctl_q.pull  <= '0;
            ctl_q.irq_n <= 1'b1;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign irq_n     = ctl_q.irq_n;
    assign addr_pull = ctl_q.pull;

    // R8: reset vector pattern appears on the next clock
    a_r8_reset_path: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rst_req |=> (addr_pull == RST_PULL && !irq_n));

    // R6: pulling only follows a fetch code or a reset request
    a_r6_pull_in_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        (|addr_pull) |-> ($past(cpu_rst_req) || $past(bus_status) == BS_FETCH));

    // R7: acknowledge releases the lines
    a_r7_ack_release: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.state != ST_IDLE && ack_now && !cpu_rst_req) |=> (addr_pull == '0));

    // R5: served source stays fixed once chosen
    a_r5_sel_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.state != ST_IDLE) |=> $stable(ctl_q.sel));

    // R4: at most one winner, and only among enabled pending sources
    a_r4_one_winner: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));
    a_r4_winner_live: assert property (@(posedge clk) disable iff (!rst_n)
        (grant & ~live) == '0);

endmodule

// File: tb/vec_irq_ctl_tb.sv
module vec_irq_ctl_tb;

    localparam int N  = 8;
    localparam int VW = 14;

    typedef struct packed {
        logic [7:0]  req;
        logic [7:0]  en;
        logic [1:0]  st;
        logic        ph;
        logic        exp_irqn;
        logic [13:0] exp_pull;
        logic [3:0]  rq;
    } row_t;

    // pull for source i is 14'h10 << i (i < 7); source 7 keeps the default vector
    localparam int ROWS = 17;
    localparam row_t TBL [ROWS] = '{
        '{8'h00, 8'hFF, 2'b00, 1'b1, 1'b1, 14'h0000, 4'd3},  // R3 idle
        '{8'h04, 8'hFF, 2'b00, 1'b1, 1'b0, 14'h0000, 4'd2},  // R2 pulse src2
        '{8'h00, 8'hFF, 2'b01, 1'b0, 1'b0, 14'h0000, 4'd1},  // R1 data code ignored
        '{8'h00, 8'hFF, 2'b10, 1'b0, 1'b0, 14'h0040, 4'd5},  // R5 fetch src2
        '{8'h01, 8'hFF, 2'b10, 1'b1, 1'b0, 14'h0040, 4'd5},  // R5 frozen vs src0
        '{8'h00, 8'hFF, 2'b11, 1'b0, 1'b0, 14'h0000, 4'd7},  // R7 ack, src0 left
        '{8'h00, 8'hFF, 2'b00, 1'b0, 1'b0, 14'h0000, 4'd1},  // R1 internal code
        '{8'h00, 8'hFF, 2'b10, 1'b0, 1'b0, 14'h0010, 4'd5},  // R5 fetch src0
        '{8'h00, 8'hFF, 2'b00, 1'b1, 1'b0, 14'h0000, 4'd6},  // R6 fetch over
        '{8'h00, 8'hFF, 2'b11, 1'b1, 1'b0, 14'h0000, 4'd1},  // R1 ack in high phase
        '{8'h00, 8'hFF, 2'b11, 1'b0, 1'b1, 14'h0000, 4'd7},  // R7 ack clears
        '{8'h00, 8'hFF, 2'b10, 1'b0, 1'b1, 14'h0000, 4'd6},  // R6 fetch, none pending
        '{8'h80, 8'h7F, 2'b00, 1'b1, 1'b1, 14'h0000, 4'd3},  // R3 disabled src7
        '{8'h00, 8'h7F, 2'b10, 1'b0, 1'b1, 14'h0000, 4'd3},  // R3 disabled not served
        '{8'h00, 8'hFF, 2'b00, 1'b1, 1'b0, 14'h0000, 4'd3},  // R3 kept, now enabled
        '{8'h00, 8'hFF, 2'b10, 1'b0, 1'b0, 14'h0000, 4'd9},  // R9 default vector
        '{8'h00, 8'hFF, 2'b11, 1'b0, 1'b1, 14'h0000, 4'd7}   // R7 ack src7
    };

    logic            clk = 1'b0;
    logic            rst_n;
    logic [N-1:0]    irq_req;
    logic [N-1:0]    irq_en;
    logic [N*VW-1:0] vec_table;
    logic [1:0]      bus_status;
    logic            cpu_clk;
    logic            cpu_rst_req;
    logic            irq_n;
    logic [VW-1:0]   addr_pull;

    int checks   = 0;
    int failures = 0;
    int cycles   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    vec_irq_ctl #(.NUM_SRC(N), .VEC_W(VW)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .irq_req     (irq_req),
        .irq_en      (irq_en),
        .vec_table   (vec_table),
        .bus_status  (bus_status),
        .cpu_clk     (cpu_clk),
        .cpu_rst_req (cpu_rst_req),
        .irq_n       (irq_n),
        .addr_pull   (addr_pull)
    );

    function automatic logic [VW-1:0] pull_of(int i);
        return (i == 7) ? 14'h0000 : (14'h0010 << i);
    endfunction

    task automatic check(string tag, logic [VW-1:0] act, logic [VW-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // drive on the falling edge, sample 1 ns after the next rising edge
    task automatic step(logic [7:0] rq, logic [7:0] en, logic [1:0] st,
                        logic ph, logic rr);
        @(negedge clk);
        irq_req     = rq;
        irq_en      = en;
        bus_status  = st;
        cpu_clk     = ph;
        cpu_rst_req = rr;
        @(posedge clk);
        #1;
    endtask

    task automatic expect_out(string tag, logic en_irqn, logic [VW-1:0] en_pull);
        check({tag, " irq_n"}, VW'(irq_n), VW'(en_irqn));
        check({tag, " addr_pull"}, addr_pull, en_pull);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 200000 && !done) begin
            done = 1'b1;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 200000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < N; i++) begin
            vec_table[i*VW +: VW] = ~pull_of(i);
        end
        rst_n       = 1'b0;
        irq_req     = '0;
        irq_en      = 8'hFF;
        bus_status  = 2'b00;
        cpu_clk     = 1'b1;
        cpu_rst_req = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        // R11 reset state
        expect_out("R11 reset", 1'b1, 14'h0000);
        step(8'h00, 8'hFF, 2'b10, 1'b0, 1'b0);
        expect_out("R11 nothing pending", 1'b1, 14'h0000);

        for (int r = 0; r < ROWS; r++) begin
            step(TBL[r].req, TBL[r].en, TBL[r].st, TBL[r].ph, 1'b0);
            expect_out($sformatf("R%0d row %0d", TBL[r].rq, r),
                       TBL[r].exp_irqn, TBL[r].exp_pull);
        end

        // R4: two sources together, lowest index first
        step(8'h0A, 8'hFF, 2'b00, 1'b1, 1'b0);
        expect_out("R4 both pending", 1'b0, 14'h0000);
        step(8'h00, 8'hFF, 2'b10, 1'b0, 1'b0);
        expect_out("R4 src1 first", 1'b0, pull_of(1));
        step(8'h00, 8'hFF, 2'b11, 1'b0, 1'b0);
        expect_out("R4 src3 remains", 1'b0, 14'h0000);
        step(8'h00, 8'hFF, 2'b10, 1'b0, 1'b0);
        expect_out("R4 src3 next", 1'b0, pull_of(3));
        step(8'h00, 8'hFF, 2'b11, 1'b0, 1'b0);
        expect_out("R4 all served", 1'b1, 14'h0000);

        // R10: request still high at its acknowledge
        step(8'h04, 8'hFF, 2'b00, 1'b1, 1'b0);
        step(8'h04, 8'hFF, 2'b10, 1'b0, 1'b0);
        expect_out("R10 fetch", 1'b0, pull_of(2));
        step(8'h04, 8'hFF, 2'b11, 1'b0, 1'b0);
        expect_out("R10 rearmed", 1'b0, 14'h0000);
        step(8'h00, 8'hFF, 2'b10, 1'b0, 1'b0);
        expect_out("R10 served again", 1'b0, pull_of(2));
        step(8'h00, 8'hFF, 2'b11, 1'b0, 1'b0);
        expect_out("R10 cleared", 1'b1, 14'h0000);

        // R8: CPU reset through the interrupt path
        step(8'h00, 8'hFF, 2'b00, 1'b1, 1'b1);
        expect_out("R8 reset vector", 1'b0, 14'h0001);
        step(8'h01, 8'hFF, 2'b10, 1'b0, 1'b1);
        expect_out("R8 held in fetch", 1'b0, 14'h0001);
        step(8'h00, 8'hFF, 2'b00, 1'b1, 1'b0);
        expect_out("R8 released, src0 pending", 1'b0, 14'h0000);
        step(8'h00, 8'hFF, 2'b10, 1'b0, 1'b0);
        expect_out("R8 src0 after reset", 1'b0, pull_of(0));
        step(8'h00, 8'hFF, 2'b10, 1'b1, 1'b1);
        expect_out("R8 aborts vector", 1'b0, 14'h0001);
        step(8'h00, 8'hFF, 2'b00, 1'b1, 1'b0);
        expect_out("R8 src0 still pending", 1'b0, 14'h0000);
        step(8'h00, 8'hFF, 2'b10, 1'b0, 1'b0);
        step(8'h00, 8'hFF, 2'b11, 1'b0, 1'b0);
        expect_out("R8 final ack", 1'b1, 14'h0000);
        step(8'h00, 8'hFF, 2'b00, 1'b1, 1'b1);
        step(8'h00, 8'hFF, 2'b00, 1'b1, 1'b0);
        expect_out("R8 clean release", 1'b1, 14'h0000);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule